// File: doc/BRIEF.md
# Serial Interrupt Frame Host

This block is the host end of a single shared, open-drain interrupt line. Peripherals report interrupt levels by pulling the line low in time slots. The host opens each packet with a long low start pulse. Every interrupt source then owns a one-clock sample slot, and two turnaround clocks follow each slot. The host closes the packet with a short low stop pulse, and the length of that stop pulse announces how the next packet will begin.

Two modes are supported. In continuous mode the host alone paces packets: it waits a programmable number of released clocks and then drives an eight-clock start pulse. In quiet mode the host does not start packets. A device that needs service pulls the line low for one clock, and the host then keeps the line low for seven more clocks, so the start pulse has the same total length in both modes. The levels sampled during a packet are gathered in a shadow register. They are copied to the output vector in a single step at the start of the stop pulse.

The line is modelled as a sense input plus an output-enable and output-value pair. The board pull-up and the wired-AND of all drivers live outside the block.

Top module: `sirq_host`

## Requirements
- R1: During reset and in the first clock after it, the host does not drive the line (sirq_oe=0), irq_level is all zero, irq_update is 0 and quiet_active is 0, which means continuous mode.
- R2: In continuous mode, after the release clock that follows a stop pulse, the host leaves the line released for exactly cfg_gap+1 clocks. It then drives the line low (sirq_oe=1, sirq_out=0) for exactly 8 consecutive clocks.
- R3: After every start pulse and after every stop pulse, the host drives the line high (sirq_oe=1, sirq_out=1) for one clock and releases it (sirq_oe=0) in the next clock.
- R4: Number the clocks after the last low clock of the start pulse from 1. Slot k (k=0 for the first slot) is sampled at clock 3k+3. A low level in that clock sets bit k of the packet's vector to 1, and a high level sets it to 0.
- R5: The host never drives the line during the slot period. This covers each sample clock and both turnaround clocks of every slot.
- R6: The number of slots N is cfg_slots. A value of 0 is treated as 1, and values above MAX_SLOTS are treated as MAX_SLOTS. Bits N and above of irq_level are 0 after the packet.
- R7: irq_level takes the new packet vector at the first stop clock, and irq_update is 1 in that clock only. irq_level holds its value at all other times.
- R8: The stop pulse lasts 3 low clocks if cfg_quiet is 0 and 2 low clocks if cfg_quiet is 1. cfg_quiet is sampled in the last clock of the last slot. The stop pulse begins in the clock after the last slot's second turnaround clock.
- R9: In quiet mode the host does not start a packet on its own. When the line is sensed low for one clock while the host is idle, the host drives it low for the next 7 clocks.
- R10: In continuous mode, a device pulling the line low while the host is idle has no effect. The start pulse still comes after exactly cfg_gap+1 released clocks.
- R11: quiet_active takes the mode chosen by the most recent stop pulse. It changes in the first idle clock after that stop pulse's turnaround.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sirq_in | input | 1 | Sensed level of the shared interrupt line |
| sirq_oe | output | 1 | Host drives the line when 1 |
| sirq_out | output | 1 | Level driven while sirq_oe is 1 |
| cfg_slots | input | SLOT_W (6) | Requested slot count per packet |
| cfg_gap | input | GAP_W (8) | Continuous-mode idle gap, in clocks minus one |
| cfg_quiet | input | 1 | 1 selects a two-clock (quiet) stop pulse |
| irq_level | output | MAX_SLOTS (32) | Latched interrupt levels, bit k for slot k |
| irq_update | output | 1 | One-clock strobe marking a new irq_level |
| quiet_active | output | 1 | 1 while quiet mode is in effect |

## Verification
The hardest cases to reach are the mode handovers. A packet that a device starts in quiet mode has to follow a two-clock stop pulse. A stray low pulse that must be ignored has to fall inside a continuous-mode idle gap that is long enough to hold it. The bench models a device that tracks packets only by watching the line. It records the configuration it chose for each stop pulse, then either waits out a quiet period and injects the one-clock wake pulse, or pokes the line in the middle of a measured idle gap. Random slot patterns, slot counts (including 0 and values above the maximum), gaps and stop lengths are mixed with directed packets that force every mode transition.

// File: rtl/sirq_pkg.sv
`timescale 1ns/1ps
package sirq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_STA,
    ST_SLOTS,
    ST_STOP,
    ST_PTA
  } sirq_state_e;

  localparam int START_LEN_HOST  = 8;
  localparam int START_LEN_QUIET = 7;
  localparam int SLOT_PERIOD     = 3;

  // Host-driven low clocks of the start pulse
  function automatic int start_len(input logic quiet);
    return quiet ? START_LEN_QUIET : START_LEN_HOST;
  endfunction

  // Low clocks of the stop pulse
  function automatic int stop_len(input logic quiet);
    return quiet ? 2 : 3;
  endfunction

  // Requested slot count clamped into 1..max_slots
  function automatic int eff_slots(input int req, input int max_slots);
    if (req < 1) return 1;
    if (req > max_slots) return max_slots;
    return req;
  endfunction

endpackage

// File: rtl/sirq_seq.sv
`timescale 1ns/1ps
module sirq_seq #(
  parameter int MAX_SLOTS = 32,
  parameter int SLOT_W    = 6,
  parameter int GAP_W     = 8,
  parameter int IDX_W     = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sirq_in,
  input  logic [SLOT_W-1:0]         cfg_slots,
  input  logic [GAP_W-1:0]          cfg_gap,
  input  logic                      cfg_quiet,
  output sirq_pkg::sirq_state_e     state,
  output logic                      ta_first,
  output logic [IDX_W-1:0]          slot_idx,
  output logic                      evt_start,
  output logic                      evt_sample,
  output logic                      evt_commit,
  output logic                      in_slots,
  output logic                      quiet_active
);
  import sirq_pkg::*;

  localparam int CNT_W = (GAP_W > 3) ? GAP_W : 3;

  logic [CNT_W-1:0]  cnt;
  logic [1:0]        ph;
  logic              start_quiet;
  logic              quiet_next;
  logic [SLOT_W-1:0] n_eff;
  logic              last_slot;
  logic              start_done;
  logic              stop_done;

  assign n_eff      = SLOT_W'(eff_slots(int'(cfg_slots), MAX_SLOTS));
  assign last_slot  = (SLOT_W'(slot_idx) == n_eff - SLOT_W'(1));
  assign start_done = (cnt == CNT_W'(start_len(start_quiet) - 1));
  assign stop_done  = (cnt == CNT_W'(stop_len(quiet_next) - 1));

  assign evt_start  = (state == ST_IDLE) &&
                      (quiet_active ? !sirq_in : (cnt >= CNT_W'(cfg_gap)));
  assign evt_sample = (state == ST_SLOTS) && (ph == 2'd0);
  assign evt_commit = (state == ST_SLOTS) && (ph == 2'd2) && last_slot;
  assign in_slots   = (state == ST_SLOTS);
  assign ta_first   = ((state == ST_STA) || (state == ST_PTA)) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      ph           <= '0;
      slot_idx     <= '0;
      start_quiet  <= 1'b0;
      quiet_next   <= 1'b0;
      quiet_active <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (evt_start) begin
            state       <= ST_START;
            cnt         <= '0;
            start_quiet <= quiet_active;
          end else if (!quiet_active) begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_START: begin
          if (start_done) begin
            state <= ST_STA;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_STA: begin
          if (cnt == CNT_W'(1)) begin
            state    <= ST_SLOTS;
            cnt      <= '0;
            ph       <= '0;
            slot_idx <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_SLOTS: begin
          if (ph == 2'd2) begin
            ph <= '0;
            if (last_slot) begin
              state      <= ST_STOP;
              cnt        <= '0;
              quiet_next <= cfg_quiet;
            end else begin
              slot_idx <= slot_idx + IDX_W'(1);
            end
          end else begin
            ph <= ph + 2'd1;
          end
        end
        ST_STOP: begin
          if (stop_done) begin
            state <= ST_PTA;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_PTA: begin
          if (cnt == CNT_W'(1)) begin
            state        <= ST_IDLE;
            cnt          <= '0;
            quiet_active <= quiet_next;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2 R9
  start_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START) |-> (cnt < CNT_W'(START_LEN_HOST)));

  // R8
  stop_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP) |-> (cnt < CNT_W'(stop_len(quiet_next))));

  // R6
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_slots |-> (SLOT_W'(slot_idx) < n_eff));

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_PTA) |=> $stable(quiet_active));

endmodule

// File: rtl/sirq_capture.sv
`timescale 1ns/1ps
module sirq_capture #(
  parameter int MAX_SLOTS = 32,
  parameter int IDX_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sirq_in,
  input  logic                 evt_start,
  input  logic                 evt_sample,
  input  logic                 evt_commit,
  input  logic [IDX_W-1:0]     slot_idx,
  output logic [MAX_SLOTS-1:0] irq_level,
  output logic                 irq_update
);
  logic [MAX_SLOTS-1:0] shadow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow     <= '0;
      irq_level  <= '0;
      irq_update <= 1'b0;
    end else begin
      irq_update <= evt_commit;
      if (evt_start) shadow <= '0;
      else if (evt_sample) shadow[slot_idx] <= ~sirq_in;
      if (evt_commit) irq_level <= shadow;
    end
  end

  // R7
  vec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_commit |=> $stable(irq_level));

  // R7
  update_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_update |=> !irq_update);

endmodule

// File: rtl/sirq_drive.sv
`timescale 1ns/1ps
module sirq_drive (
  input  sirq_pkg::sirq_state_e state,
  input  logic                  ta_first,
  output logic                  sirq_oe,
  output logic                  sirq_out
);
  import sirq_pkg::*;

  always_comb begin
    sirq_oe  = 1'b0;
    sirq_out = 1'b1;
    unique case (state)
      ST_START, ST_STOP: begin
        sirq_oe  = 1'b1;
        sirq_out = 1'b0;
      end
      ST_STA, ST_PTA: begin
        sirq_oe  = ta_first;
        sirq_out = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sirq_host.sv
`timescale 1ns/1ps
module sirq_host #(
  parameter int MAX_SLOTS = 32,
  parameter int GAP_W     = 8,
  parameter int SLOT_W    = $clog2(MAX_SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sirq_in,
  output logic                 sirq_oe,
  output logic                 sirq_out,
  input  logic [SLOT_W-1:0]    cfg_slots,
  input  logic [GAP_W-1:0]     cfg_gap,
  input  logic                 cfg_quiet,
  output logic [MAX_SLOTS-1:0] irq_level,
  output logic                 irq_update,
  output logic                 quiet_active
);
  localparam int IDX_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1;

  sirq_pkg::sirq_state_e state;
  logic             ta_first;
  logic [IDX_W-1:0] slot_idx;
  logic             evt_start;
  logic             evt_sample;
  logic             evt_commit;
  logic             in_slots;

  sirq_seq #(
    .MAX_SLOTS(MAX_SLOTS), .SLOT_W(SLOT_W), .GAP_W(GAP_W), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .sirq_in(sirq_in),
    .cfg_slots(cfg_slots), .cfg_gap(cfg_gap), .cfg_quiet(cfg_quiet),
    .state(state), .ta_first(ta_first), .slot_idx(slot_idx),
    .evt_start(evt_start), .evt_sample(evt_sample), .evt_commit(evt_commit),
    .in_slots(in_slots), .quiet_active(quiet_active)
  );

  sirq_capture #(.MAX_SLOTS(MAX_SLOTS), .IDX_W(IDX_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .sirq_in(sirq_in),
    .evt_start(evt_start), .evt_sample(evt_sample), .evt_commit(evt_commit),
    .slot_idx(slot_idx), .irq_level(irq_level), .irq_update(irq_update)
  );

  sirq_drive u_drv (
    .state(state), .ta_first(ta_first),
    .sirq_oe(sirq_oe), .sirq_out(sirq_out)
  );

  // R5
  slot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_slots |-> !sirq_oe);

  // R3
  ta_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sirq_oe && sirq_out) |=> !sirq_oe);

  // R7
  commit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_commit |=> (irq_update && sirq_oe && !sirq_out));

  // R4
  sample_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sample |-> (in_slots && !sirq_oe));

endmodule

// File: tb/sirq_host_test.sv
`timescale 1ns/1ps
module sirq_host_test;
  localparam int MAXS = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dev_low = 1'b0;
  logic        sirq_oe, sirq_out, line;
  logic [5:0]  cfg_slots = 6'd17;
  logic [7:0]  cfg_gap = 8'd5;
  logic        cfg_quiet = 1'b0;
  logic [31:0] irq_level;
  logic        irq_update, quiet_active;

  int tests = 0;
  int fails = 0;
  bit mode_q = 1'b0;
  int exp_idle = -1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign line = sirq_oe ? sirq_out : ~dev_low;

  sirq_host uut (
    .clk(clk), .rst_n(rst_n), .sirq_in(line),
    .sirq_oe(sirq_oe), .sirq_out(sirq_out),
    .cfg_slots(cfg_slots), .cfg_gap(cfg_gap), .cfg_quiet(cfg_quiet),
    .irq_level(irq_level), .irq_update(irq_update), .quiet_active(quiet_active)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int clamp_n(input int n);
    return (n == 0) ? 1 : ((n > MAXS) ? MAXS : n);
  endfunction

  function automatic logic [31:0] expect_vec(input logic [31:0] pat, input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < clamp_n(n); i++) v[i] = pat[i];
    return v;
  endfunction

  task automatic packet(input logic [31:0] pat, input int slots, input bit q_stop, input int gap_after);
    int n, idle, lows, bad, s;
    n = clamp_n(slots);
    cfg_slots = 6'(slots);
    cfg_quiet = q_stop;
    @(negedge clk);
    chk(quiet_active == mode_q, "R11 mode flag", quiet_active, mode_q);
    if (mode_q) begin
      bad = 0;
      for (int i = 0; i < 40; i++) begin
        if (sirq_oe) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R9 quiet no host start", bad, 0);
      dev_low = 1'b1;
      @(negedge clk);
      dev_low = 1'b0;
      lows = 0;
      while (sirq_oe && !sirq_out && lows < 50) begin
        lows++;
        @(negedge clk);
      end
      chk(lows == 7, "R9 host extends wake pulse", lows, 7);
    end else begin
      idle = 0;
      while (!sirq_oe && idle < 1000) begin
        idle++;
        dev_low = (exp_idle >= 5 && idle == 2);
        @(negedge clk);
      end
      dev_low = 1'b0;
      if (exp_idle >= 0)
        chk(idle == exp_idle, "R2 R10 idle gap", idle, exp_idle);
      lows = 0;
      while (sirq_oe && !sirq_out && lows < 50) begin
        lows++;
        @(negedge clk);
      end
      chk(lows == 8, "R2 start length", lows, 8);
    end
    chk(sirq_oe && sirq_out, "R3 start drive high", {sirq_oe, sirq_out}, 2'b11);
    @(negedge clk);
    chk(!sirq_oe, "R3 start release", sirq_oe, 0);
    bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (sirq_oe) bad++;
      dev_low = pat[k];
      @(negedge clk);
      dev_low = 1'b0;
      if (sirq_oe) bad++;
      @(negedge clk);
      if (sirq_oe) bad++;
    end
    chk(bad == 0, "R5 no drive in slots", bad, 0);
    @(negedge clk);
    chk(irq_update == 1'b1, "R7 update strobe", irq_update, 1);
    chk(irq_level == expect_vec(pat, slots), "R4 R6 vector", irq_level, expect_vec(pat, slots));
    cfg_gap = 8'(gap_after);
    s = 0;
    while (sirq_oe && !sirq_out && s < 10) begin
      s++;
      if (s == 2) chk(irq_update == 1'b0, "R7 strobe one clock", irq_update, 0);
      @(negedge clk);
    end
    chk(s == (q_stop ? 2 : 3), "R8 stop length", s, q_stop ? 2 : 3);
    chk(sirq_oe && sirq_out, "R3 stop drive high", {sirq_oe, sirq_out}, 2'b11);
    @(negedge clk);
    chk(!sirq_oe, "R3 stop release", sirq_oe, 0);
    chk(irq_level == expect_vec(pat, slots), "R7 vector held", irq_level, expect_vec(pat, slots));
    mode_q = q_stop;
    exp_idle = gap_after + 1;
  endtask

  initial begin
    #600000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, first clock after reset
    chk(!sirq_oe && irq_level == 0 && !irq_update && !quiet_active,
        "R1 reset state", {sirq_oe, irq_update, quiet_active}, 0);
    packet(32'h0001_A5C3, 17, 1'b0, 6);
    packet(32'hFFFF_FFFF, 0, 1'b0, 0);        // R6 zero clamps to one
    packet(32'hDEAD_BEEF, 63, 1'b0, 9);       // R6 clamps to max
    packet(32'h0000_8001, 17, 1'b1, 3);       // R8 quiet stop
    packet(32'h0000_0015, 5, 1'b1, 2);        // R9 device-started packet
    packet(32'h0000_01FF, 9, 1'b0, 7);        // back to continuous
    packet(32'h0000_0000, 17, 1'b0, 4);       // R10 poke in idle
    for (int i = 0; i < 25; i++) begin
      packet($urandom, int'($urandom % 40), ($urandom % 4) == 0, int'($urandom % 12));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule